// File: doc/BRIEF.md
# Memory-Reference Instruction Executor

This block carries out the seven instructions of a small 16-bit accumulator machine that take an operand address in memory: logical AND into the accumulator, add into the accumulator, load the accumulator, store the accumulator, unconditional jump, jump to subroutine with the return address saved, and increment with skip on zero. An external fetch and decode unit owns the program counter, the accumulator and the carry bit E. It pulses `go` in timing step T3 with the one-hot opcode lines, the indirect flag and the 12-bit address. The executor then drives a synchronous 4096 x 16 memory port and load strobes for the external registers in steps T4, T5 and T6. It raises `done` for one cycle in the last step of each instruction so that the fetch unit can clear its sequence counter.

Data comes back from the memory one cycle after a read is issued. For this reason the operand word is read in T4 and used in T5. An indirect instruction adds one pointer-read cycle between T3 and T4, and the low 12 bits of the word read there become the effective address.

The controller is a five-state machine:
- IDLE waits for `go`.
- PTR takes in the pointer word.
- T4, T5 and T6 are the execution steps.

The transitions are:
- IDLE goes to PTR on `go` with `ind`=1, or to T4 on `go` with `ind`=0.
- PTR always goes to T4.
- T4 goes to IDLE for store and jump, and to T5 otherwise.
- T5 goes to T6 for increment-and-skip, and to IDLE otherwise.
- T6 always goes to IDLE.

Top module: `mre_exec`

## Requirements
- R1: After reset the block is idle. `done`, `mem_rd`, `mem_we`, `pc_ld`, `ac_ld` and `e_ld` are all low until a `go` is accepted.
- R2: With `ind`=0 the effective address is `ar`, and T4 is the cycle right after `go`. With `ind`=1 the block reads M[`ar`] in the `go` cycle, and the low 12 bits of that word become the effective address. This adds one cycle before T4.
- R3: AND, ADD and LDA read M[EA] in T4. In T5 they pulse `ac_ld` and `done`. The value loaded is AC & M, (AC + M) mod 2^16 or M respectively. ADD also pulses `e_ld` with the carry-out. AND and LDA leave E unchanged.
- R4: STA writes AC to M[EA] in T4 and pulses `done` in that cycle. `mem_rd` and `mem_we` are never high together.
- R5: BUN pulses `pc_ld` with EA in T4 and pulses `done` in that cycle.
- R6: BSA writes the zero-extended PC to M[EA] in T4. In T5 it loads PC with EA+1 and pulses `done`. For example, with EA=135 and PC=21, word 135 becomes 21 and PC becomes 136.
- R7: ISZ reads M[EA] in T4 and writes M+1 back in T6. If the incremented word is zero, it also loads PC with PC+1 in T6, which skips the next instruction. It pulses `done` in T6.
- R8: `done` is high for exactly one cycle per instruction. A `go` that arrives while an instruction is in progress is ignored.
- R9: The bits of `dline` select the operations as follows: bit 0 AND, bit 1 ADD, bit 2 LDA, bit 3 STA, bit 4 BUN, bit 5 BSA, bit 6 ISZ. The lines are one-hot whenever `go` is high, and a `go` with all lines low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start pulse in T3 for a memory-reference instruction |
| dline | input | 7 | One-hot decoded opcode lines |
| ind | input | 1 | Indirect addressing flag |
| ar | input | 12 | Address field from the instruction |
| pc | input | 12 | Current program counter (already pointing past this instruction) |
| ac | input | 16 | Current accumulator |
| mem_rdata | input | 16 | Memory read data, valid the cycle after `mem_rd` |
| mem_rd | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 12 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| pc_ld | output | 1 | Load strobe for the program counter |
| pc_val | output | 12 | New program counter value |
| ac_ld | output | 1 | Load strobe for the accumulator |
| ac_val | output | 16 | New accumulator value |
| e_ld | output | 1 | Load strobe for the carry bit E |
| e_val | output | 1 | New E value |
| done | output | 1 | Last step of the instruction |

## Verification
In T6 of an increment-and-skip, the memory write-back and the program-counter skip fall in the same cycle.

The bench provokes this with a directed case whose operand is 0xFFFF, and random operands cover the non-skipping path. For each case it judges three things:
- the stored word is 0;
- PC has advanced by exactly one;
- `done` came in the third cycle after `go`, or the fourth when the instruction is indirect.

A second overlap, a new `go` arriving while an instruction is still running, is forced by holding `go` high with a different opcode one cycle late. The bench then checks that only the first instruction's effects and a single `done` appear.

// File: rtl/mre_pkg.sv
package mre_pkg;
    typedef enum logic [2:0] {
        OP_AND = 3'd0,
        OP_ADD = 3'd1,
        OP_LDA = 3'd2,
        OP_STA = 3'd3,
        OP_BUN = 3'd4,
        OP_BSA = 3'd5,
        OP_ISZ = 3'd6
    } mre_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PTR,
        ST_T4,
        ST_T5,
        ST_T6
    } mre_state_e;
endpackage

// File: rtl/mre_opdec.sv
module mre_opdec #(
    parameter int NOPS = 7
) (
    input  logic [NOPS-1:0]     dline,
    output mre_pkg::mre_op_e    op,
    output logic                any
);
    import mre_pkg::*;

    always_comb begin
        op = OP_AND;
        for (int i = NOPS - 1; i >= 0; i--) begin
            if (dline[i]) begin
                op = mre_op_e'(i[2:0]);
            end
        end
    end

    assign any = |dline;
endmodule

// File: rtl/mre_alu.sv
module mre_alu #(
    parameter int DW = 16
) (
    input  mre_pkg::mre_op_e op,
    input  logic [DW-1:0]    ac,
    input  logic [DW-1:0]    mdata,
    output logic [DW-1:0]    res,
    output logic             carry,
    output logic [DW-1:0]    inc
);
    import mre_pkg::*;

    logic [DW:0] sum;

    always_comb begin
        sum   = {1'b0, ac} + {1'b0, mdata};
        carry = sum[DW];
        inc   = mdata + {{(DW-1){1'b0}}, 1'b1};
        unique case (op)
            OP_AND:  res = ac & mdata;
            OP_ADD:  res = sum[DW-1:0];
            default: res = mdata;
        endcase
    end
endmodule

// File: rtl/mre_exec.sv
module mre_exec #(
    parameter int AW   = 12,
    parameter int DW   = 16,
    parameter int NOPS = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic [NOPS-1:0] dline,
    input  logic            ind,
    input  logic [AW-1:0]   ar,
    input  logic [AW-1:0]   pc,
    input  logic [DW-1:0]   ac,
    input  logic [DW-1:0]   mem_rdata,
    output logic            mem_rd,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic            pc_ld,
    output logic [AW-1:0]   pc_val,
    output logic            ac_ld,
    output logic [DW-1:0]   ac_val,
    output logic            e_ld,
    output logic            e_val,
    output logic            done
);
    import mre_pkg::*;

    localparam int PADW = DW - AW;

    mre_state_e state_q, state_d;
    mre_op_e    op_q, op_dec;
    logic       op_any;
    logic [AW-1:0] ea_q;
    logic [DW-1:0] dr_q;
    logic [DW-1:0] alu_res, alu_inc;
    logic          alu_carry;
    logic          accept;

    mre_opdec #(.NOPS(NOPS)) i_dec (
        .dline (dline),
        .op    (op_dec),
        .any   (op_any)
    );

    mre_alu #(.DW(DW)) i_alu (
        .op    (op_q),
        .ac    (ac),
        .mdata (mem_rdata),
        .res   (alu_res),
        .carry (alu_carry),
        .inc   (alu_inc)
    );

    assign accept = (state_q == ST_IDLE) && go && op_any;

    // State register and datapath holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_AND;
            ea_q    <= '0;
            dr_q    <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_q <= op_dec;
                ea_q <= ar;
            end
            if (state_q == ST_PTR) begin
                ea_q <= mem_rdata[AW-1:0];
            end
            if (state_q == ST_T5 && op_q == OP_ISZ) begin
                dr_q <= alu_inc;
            end
        end
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        mem_rd    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ea_q;
        mem_wdata = '0;
        pc_ld     = 1'b0;
        pc_val    = pc;
        ac_ld     = 1'b0;
        ac_val    = alu_res;
        e_ld      = 1'b0;
        e_val     = alu_carry;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (ind) begin
                        mem_rd   = 1'b1;
                        mem_addr = ar;
                        state_d  = ST_PTR;
                    end else begin
                        state_d  = ST_T4;
                    end
                end
            end
            ST_PTR: begin
                state_d = ST_T4;
            end
            ST_T4: begin
                state_d = ST_T5;
                unique case (op_q)
                    OP_STA: begin
                        mem_we    = 1'b1;
                        mem_wdata = ac;
                        done      = 1'b1;
                        state_d   = ST_IDLE;
                    end
                    OP_BUN: begin
                        pc_ld   = 1'b1;
                        pc_val  = ea_q;
                        done    = 1'b1;
                        state_d = ST_IDLE;
                    end
                    OP_BSA: begin
                        mem_we    = 1'b1;
                        mem_wdata = {{PADW{1'b0}}, pc};
                    end
                    default: begin
                        mem_rd = 1'b1;
                    end
                endcase
            end
            ST_T5: begin
                state_d = ST_IDLE;
                unique case (op_q)
                    OP_ISZ: begin
                        state_d = ST_T6;
                    end
                    OP_BSA: begin
                        pc_ld  = 1'b1;
                        pc_val = ea_q + {{(AW-1){1'b0}}, 1'b1};
                        done   = 1'b1;
                    end
                    default: begin
                        ac_ld = 1'b1;
                        e_ld  = (op_q == OP_ADD);
                        done  = 1'b1;
                    end
                endcase
            end
            ST_T6: begin
                mem_we    = 1'b1;
                mem_wdata = dr_q;
                done      = 1'b1;
                if (dr_q == '0) begin
                    pc_ld  = 1'b1;
                    pc_val = pc + {{(AW-1){1'b0}}, 1'b1};
                end
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_NO_RD_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_we)); // R4
    AST_GO_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> $onehot0(dline)); // R9
    AST_AC_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ac_ld |-> $past(mem_rd)); // R3
    AST_BSA_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_BSA) |-> $past(mem_we)); // R6
    AST_ISZ_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && op_q == OP_ISZ) |-> $past(mem_rd, 2)); // R7
endmodule

// File: tb/test_mre_exec.sv
module test_mre_exec;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic [6:0]  dline = '0;
    logic        ind = 1'b0;
    logic [11:0] ar = '0;
    logic [11:0] pc;
    logic [15:0] ac;
    logic        e;
    logic [15:0] rdata;
    logic        mem_rd, mem_we, pc_ld, ac_ld, e_ld, e_val, done;
    logic [11:0] mem_addr, pc_val;
    logic [15:0] mem_wdata, ac_val;

    logic [15:0] mem [0:4095];
    logic        pk_we = 1'b0;
    logic [11:0] pk_addr = '0;
    logic [15:0] pk_data = '0;
    logic        pk_reg = 1'b0;
    logic [11:0] pk_pc = '0;
    logic [15:0] pk_ac = '0;
    logic        pk_e = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mre_exec i_mre_exec (
        .clk(clk), .rst_n(rst_n), .go(go), .dline(dline), .ind(ind), .ar(ar),
        .pc(pc), .ac(ac), .mem_rdata(rdata), .mem_rd(mem_rd), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .pc_ld(pc_ld), .pc_val(pc_val),
        .ac_ld(ac_ld), .ac_val(ac_val), .e_ld(e_ld), .e_val(e_val), .done(done)
    );

    // External registers and synchronous memory
    always @(posedge clk) begin
        if (pk_we) mem[pk_addr] <= pk_data;
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_rd) rdata <= mem[mem_addr];
        if (pk_reg) begin
            pc <= pk_pc; ac <= pk_ac; e <= pk_e;
        end else begin
            if (pc_ld) pc <= pc_val;
            if (ac_ld) ac <= ac_val;
            if (e_ld)  e  <= e_val;
        end
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic string op_tag(input int op);
        case (op)
            0, 1, 2: return "R3";
            3:       return "R4";
            4:       return "R5";
            5:       return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic run(input int op, input bit ind_i, input logic [11:0] ea,
                       input logic [11:0] arp_i, input logic [3:0] ptrhi, input logic [15:0] m,
                       input logic [11:0] pc0, input logic [15:0] ac0, input bit e0, input bit busy_go);
        logic [11:0] arp = arp_i;
        logic [11:0] exp_pc = pc0;
        logic [15:0] exp_ac = ac0;
        logic        exp_e = e0;
        logic [15:0] exp_m = m;
        logic [16:0] s;
        int base, exp_cyc, ndone = 0, dcyc = -1;
        string tag = op_tag(op);
        if (arp == ea) arp = arp ^ 12'h001;
        @(negedge clk);
        pk_we = 1'b1; pk_addr = ea; pk_data = m;
        pk_reg = 1'b1; pk_pc = pc0; pk_ac = ac0; pk_e = e0;
        @(negedge clk);
        pk_reg = 1'b0;
        pk_we = ind_i; pk_addr = arp; pk_data = {ptrhi, ea};
        @(negedge clk);
        pk_we = 1'b0;
        go = 1'b1; dline = 7'(1 << op); ind = ind_i; ar = ind_i ? arp : ea;
        for (int cyc = 1; cyc <= 8; cyc++) begin
            @(negedge clk);
            if (done) begin ndone++; dcyc = cyc; end
            if (cyc == 1 && busy_go) begin
                go = 1'b1; dline = 7'b0010000; ind = 1'b0; ar = ea ^ 12'h0F0;
            end else begin
                go = 1'b0; dline = '0; ind = 1'b0;
            end
        end
        // Expected results from the requirements
        case (op)
            0: exp_ac = ac0 & m;
            1: begin s = {1'b0, ac0} + {1'b0, m}; exp_ac = s[15:0]; exp_e = s[16]; end
            2: exp_ac = m;
            3: exp_m = ac0;
            4: exp_pc = ea;
            5: begin exp_m = {4'b0, pc0}; exp_pc = ea + 12'd1; end
            default: begin exp_m = m + 16'd1; if (exp_m == 16'd0) exp_pc = pc0 + 12'd1; end
        endcase
        base = (op == 3 || op == 4) ? 1 : (op == 6 ? 3 : 2);
        exp_cyc = base + (ind_i ? 1 : 0);
        chk("R8", "done pulses", ndone, 1);
        chk(ind_i ? "R2" : tag, "done cycle", dcyc, exp_cyc);
        chk({tag, "/R9"}, "pc", {20'd0, pc}, {20'd0, exp_pc});
        chk({tag, "/R9"}, "ac", {16'd0, ac}, {16'd0, exp_ac});
        chk({tag, "/R9"}, "e", {31'd0, e}, {31'd0, exp_e});
        chk({tag, "/R9"}, "mem[ea]", {16'd0, mem[ea]}, {16'd0, exp_m});
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1: idle outputs while in reset and after release
        chk("R1", "done in reset", {31'd0, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "strobes after reset", {26'd0, done, mem_rd, mem_we, pc_ld, ac_ld, e_ld}, 0);
        // R9: go with no opcode line is ignored
        go = 1'b1; dline = '0; ar = 12'h123;
        @(negedge clk);
        go = 1'b0;
        chk("R9", "no-line go strobes", {28'd0, mem_rd, mem_we, pc_ld, done}, 0);
        repeat (4) begin
            @(negedge clk);
            chk("R9", "no-line go done", {31'd0, done}, 0);
        end
        // Directed corner cases
        run(5, 0, 12'd135, 12'd0, 4'h0, 16'h1234, 12'd21, 16'h0042, 0, 0);   // R6 example
        run(1, 0, 12'h010, 12'd0, 4'h0, 16'h0001, 12'h200, 16'hFFFF, 0, 0);  // R3 carry out
        run(1, 0, 12'h011, 12'd0, 4'h0, 16'h0001, 12'h200, 16'h0001, 1, 0);  // R3 no carry clears E
        run(6, 0, 12'h020, 12'd0, 4'h0, 16'hFFFF, 12'h300, 16'h0000, 0, 0);  // R7 skip
        run(6, 1, 12'h021, 12'h400, 4'hA, 16'h0005, 12'h301, 16'h0000, 0, 0); // R7 no skip, R2 indirect
        run(3, 1, 12'h7FF, 12'h055, 4'hF, 16'hDEAD, 12'h010, 16'hBEEF, 1, 0); // R4 R2
        run(4, 1, 12'hABC, 12'h001, 4'h3, 16'h0000, 12'h010, 16'h0000, 0, 0); // R5 R2
        run(0, 0, 12'h030, 12'd0, 4'h0, 16'hF0F0, 12'h001, 16'h3C3C, 1, 1);  // R8 busy go ignored
        run(6, 0, 12'h031, 12'd0, 4'h0, 16'hFFFF, 12'hFFF, 16'h0000, 0, 1);  // R8 busy go, R7 skip wrap
        // Constrained random
        for (int n = 0; n < 300; n++) begin
            int op = $urandom_range(0, 6);
            bit indr = $urandom_range(0, 1) == 1;
            logic [15:0] mv = ($urandom_range(0, 7) == 0) ? 16'hFFFF : 16'($urandom);
            run(op, indr, 12'($urandom), 12'($urandom), 4'($urandom), mv,
                12'($urandom), 16'($urandom), ($urandom_range(0, 1) == 1),
                ($urandom_range(0, 9) == 0));
        end
        summary();
    end
endmodule